// File: doc/BRIEF.md
# Bitstream Header Ratio Detector

This block watches a configuration image as it streams past, one 32-bit word per valid beat, and works out the clock-to-data ratio code the configuration path needs. It only observes the stream and never stalls or alters it. Two header words matter. Word 69 (counting from 0) carries a two-bit encryption field in bits [3:2]. Word 229 carries a compression indicator in bit 1, and that bit is active low.

A beat that has both `sopIn` and `validIn` high starts a new image, and that beat is word 0. The width select is taken from that beat. Once word 229 has been accepted, the block raises a one-cycle `resultValid` pulse and holds the ratio code and both flags until the next start of image. If the image ends before word 229, `shortErr` is raised and no result is produced.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, `encFlag`, `cmpFlag`, `ratioCode`, `resultValid` and `shortErr` are all 0.
- R2: `encFlag` is 1 from the cycle after word 69 is accepted when bits [3:2] of that word are not 00. When those bits are 00 it is 0.
- R3: `cmpFlag` is 1 from the cycle after word 229 is accepted when bit 1 of that word is 0. When that bit is 1 it is 0.
- R4: `ratioCode` uses 0 for x1, 1 for x2, 2 for x4 and 3 for x8. With neither flag set the code is 0. With compression the code is 2, plus 1 in 32-bit mode. With encryption alone the code is 1, plus 1 in 32-bit mode.
- R5: `resultValid` is high for exactly one cycle, the cycle after word 229 is accepted. Beats with `validIn` low are not counted as words.
- R6: The width is sampled from `widthIn` on the start beat (1 = 32-bit, 0 = 16-bit). Later values of `widthIn` have no effect on the result.
- R7: A beat with `lastIn` high at word index below 229 sets `shortErr` from the next cycle until the next start of image, and no `resultValid` follows for that image. `lastIn` on word 229 itself raises no error.
- R8: After a result, further beats (including `lastIn`) leave all outputs unchanged until the next start of image.
- R9: A start beat clears both flags, the ratio code and `shortErr`, and counts as word 0, even when it arrives in the middle of an image.
- R10: Beats that arrive after reset but before any start beat are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | A word is present on `dataIn` |
| sopIn | input | 1 | The current beat is word 0 of a new image |
| lastIn | input | 1 | The current beat is the final word of the image |
| dataIn | input | 32 | Stream word |
| widthIn | input | 1 | Configuration width select: 1 = 32-bit, 0 = 16-bit |
| encFlag | output | 1 | The image is encrypted |
| cmpFlag | output | 1 | The image is compressed |
| ratioCode | output | 2 | Clock-to-data ratio code |
| resultValid | output | 1 | One-cycle pulse when the ratio code is ready |
| shortErr | output | 1 | The image ended before the header was complete |

## Verification
Every result is registered once after the beat that causes it:
- `encFlag` is due in the cycle after word 69.
- `cmpFlag`, `ratioCode` and `resultValid` are due in the cycle after word 229.
- `shortErr` is due in the cycle after the early last beat.

The bench drives inputs on falling edges. It checks the result of each word at the first falling edge after the rising edge that accepted it, which is before any gap beat or later word is driven. One falling edge later it confirms that the pulse has dropped. Gap beats are inserted in some images, so a result that is due is tied to the count of accepted words and not to elapsed cycles.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  typedef struct packed {
    logic clearAll;
    logic capEnc;
    logic finish;
    logic flagErr;
  } hdrStrb_t;

  function automatic logic [1:0] ratio_pick(logic enc, logic cmp, logic wide);
    logic [1:0] base;
    if (!enc && !cmp) return 2'd0;
    base = cmp ? 2'd2 : 2'd1;
    return base + {1'b0, wide};
  endfunction

endpackage

// File: rtl/hdr_ctrl.sv
module hdr_ctrl
  import hdr_pkg::*;
#(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     validIn,
  input  logic     sopIn,
  input  logic     lastIn,
  output hdrStrb_t strb
);
  localparam int IDX_W = $clog2(CMP_IDX + 1);
  localparam logic [IDX_W-1:0] ENC_AT = IDX_W'(ENC_IDX);
  localparam logic [IDX_W-1:0] CMP_AT = IDX_W'(CMP_IDX);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_DONE} ctrlState_t;

  ctrlState_t state;
  logic [IDX_W-1:0] idx, curIdx;
  logic startBeat, accept;

  initial begin
    assert (ENC_IDX < CMP_IDX) else $error("encryption word must precede compression word");
  end

  always_comb begin
    startBeat     = validIn & sopIn;
    curIdx        = startBeat ? '0 : idx;
    accept        = startBeat | (validIn & (state == S_ARMED));
    strb.clearAll = startBeat;
    strb.capEnc   = accept & (curIdx == ENC_AT);
    strb.finish   = accept & (curIdx == CMP_AT);
    strb.flagErr  = accept & lastIn & (curIdx < CMP_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
    end else if (strb.finish) begin
      state <= S_DONE;
    end else if (strb.flagErr) begin
      state <= S_IDLE;
    end else if (accept) begin
      state <= S_ARMED;
      idx   <= curIdx + 1'b1;
    end
  end

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED) |-> (idx <= CMP_AT));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !sopIn) |-> !(strb.finish || strb.flagErr || strb.capEnc));

endmodule

// File: rtl/hdr_datapath.sv
module hdr_datapath
  import hdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hdrStrb_t          strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              widthIn,
  output logic              encFlag,
  output logic              cmpFlag,
  output logic [1:0]        ratioCode,
  output logic              resultValid,
  output logic              shortErr
);
  logic wideReg;
  logic encNow, cmpNow;

  always_comb begin
    encNow = |dataIn[ENC_LSB +: ENC_W];
    cmpNow = ~dataIn[CMP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      encFlag     <= 1'b0;
      cmpFlag     <= 1'b0;
      ratioCode   <= 2'd0;
      resultValid <= 1'b0;
      shortErr    <= 1'b0;
      wideReg     <= 1'b0;
    end else begin
      resultValid <= strb.finish;
      if (strb.clearAll) begin
        encFlag   <= 1'b0;
        cmpFlag   <= 1'b0;
        ratioCode <= 2'd0;
        shortErr  <= 1'b0;
        wideReg   <= widthIn;
      end
      if (strb.capEnc) encFlag <= encNow;
      if (strb.finish) begin
        cmpFlag   <= cmpNow;
        ratioCode <= ratio_pick(encFlag, cmpNow, wideReg);
      end
      if (strb.flagErr) shortErr <= 1'b1;
    end
  end

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resultValid && shortErr));

  // R4
  plain_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !encFlag && !cmpFlag) |-> (ratioCode == 2'd0));

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clearAll && !strb.finish) |=> $stable(ratioCode));

  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearAll && !strb.capEnc && !strb.flagErr) |=> (!encFlag && !shortErr));

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              validIn,
  input  logic              sopIn,
  input  logic              lastIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              widthIn,
  output logic              encFlag,
  output logic              cmpFlag,
  output logic [1:0]        ratioCode,
  output logic              resultValid,
  output logic              shortErr
);
  hdrStrb_t strb;

  hdr_ctrl #(.ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .sopIn(sopIn),
    .lastIn(lastIn), .strb(strb)
  );

  hdr_datapath #(.DATA_W(DATA_W), .ENC_LSB(ENC_LSB), .ENC_W(ENC_W),
                 .CMP_BIT(CMP_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dataIn(dataIn),
    .widthIn(widthIn), .encFlag(encFlag), .cmpFlag(cmpFlag),
    .ratioCode(ratioCode), .resultValid(resultValid), .shortErr(shortErr)
  );

endmodule

// File: tb/sim_hdr_ratio_detect.sv
module sim_hdr_ratio_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic validIn = 1'b0, sopIn = 1'b0, lastIn = 1'b0, widthIn = 1'b0;
  logic [31:0] dataIn = '0;
  logic encFlag, cmpFlag, resultValid, shortErr;
  logic [1:0] ratioCode;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdr_ratio_detect u0 (
    .clk(clk), .rst_n(rst_n), .validIn(validIn), .sopIn(sopIn),
    .lastIn(lastIn), .dataIn(dataIn), .widthIn(widthIn),
    .encFlag(encFlag), .cmpFlag(cmpFlag), .ratioCode(ratioCode),
    .resultValid(resultValid), .shortErr(shortErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(int i, logic [1:0] e, logic c);
    logic [31:0] w;
    w = i[0] ? 32'h0 : 32'hFFFF_FFFF;
    if (i == 69) w[3:2] = e;
    if (i == 229) w[1] = c;
    return w;
  endfunction

  function automatic logic [1:0] expRatio(logic enc, logic cmp, logic wide);
    if (!enc && !cmp) return 2'd0;
    return (cmp ? 2'd2 : 2'd1) + {1'b0, wide};
  endfunction

  task automatic afterWord(int j, int n, logic [1:0] e, logic c, logic wide,
                           bit doSop, bit doLast);
    bit full;
    full = doSop && n >= 230;
    if (!doSop) return;
    if (j == 0 && !(doLast && n == 1)) begin
      chk("R9 clear err", {31'h0, shortErr}, 0);
      chk("R9 clear enc", {31'h0, encFlag}, 0);
      chk("R9 clear ratio", {30'h0, ratioCode}, 0);
    end
    if (j == 69) chk("R2 encFlag", {31'h0, encFlag}, {31'h0, e != 2'b00});
    if (j == 228 && full) chk("R5 not early", {31'h0, resultValid}, 0);
    if (j == 229 && full) begin
      chk("R5 resultValid", {31'h0, resultValid}, 1);
      chk("R3 cmpFlag", {31'h0, cmpFlag}, {31'h0, !c});
      chk("R4 R6 ratioCode", {30'h0, ratioCode}, {30'h0, expRatio(e != 2'b00, !c, wide)});
      chk("R7 no err on 229", {31'h0, shortErr}, 0);
    end
    if (doLast && j == n - 1 && j < 229) begin
      chk("R7 shortErr", {31'h0, shortErr}, 1);
      chk("R7 no result", {31'h0, resultValid}, 0);
    end
  endtask

  task automatic sendImage(int n, logic [1:0] e, logic c, logic wide,
                           bit gaps, bit doSop, bit doLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) afterWord(i - 1, n, e, c, wide, doSop, doLast);
      if (gaps && (i % 5 == 2)) begin
        validIn = 1'b0;
        sopIn = 1'b0;
        lastIn = 1'b0;
        @(negedge clk);
      end
      validIn = 1'b1;
      sopIn   = doSop && (i == 0);
      lastIn  = doLast && (i == n - 1);
      widthIn = (i == 0) ? wide : ~wide;
      dataIn  = wordOf(i, e, c);
    end
    @(negedge clk);
    validIn = 1'b0;
    sopIn = 1'b0;
    lastIn = 1'b0;
    afterWord(n - 1, n, e, c, wide, doSop, doLast);
    @(negedge clk);
    if (doSop && n >= 230) chk("R5 pulse ends", {31'h0, resultValid}, 0);
  endtask

  initial begin
    logic [1:0] holdR;
    repeat (3) @(negedge clk);
    chk("R1 enc", {31'h0, encFlag}, 0);
    chk("R1 cmp", {31'h0, cmpFlag}, 0);
    chk("R1 ratio", {30'h0, ratioCode}, 0);
    chk("R1 valid", {31'h0, resultValid}, 0);
    chk("R1 err", {31'h0, shortErr}, 0);
    rst_n = 1'b1;

    // R10: no start beat yet, words ignored
    sendImage(240, 2'b11, 1'b0, 1'b1, 0, 0, 1);
    chk("R10 enc", {31'h0, encFlag}, 0);
    chk("R10 cmp", {31'h0, cmpFlag}, 0);
    chk("R10 err", {31'h0, shortErr}, 0);
    chk("R10 ratio", {30'h0, ratioCode}, 0);

    // R2 R3 R4 R6 sweep over every flag and width combination
    for (int k = 0; k < 16; k++) begin
      sendImage(230, k[1:0], k[2], k[3], k[0] ^ k[3], 1, 1);
    end

    // R8: beats after a result change nothing
    sendImage(230, 2'b01, 1'b0, 1'b0, 0, 1, 0);
    holdR = ratioCode;
    sendImage(20, 2'b11, 1'b0, 1'b1, 0, 0, 1);
    chk("R8 ratio held", {30'h0, ratioCode}, {30'h0, holdR});
    chk("R8 cmp held", {31'h0, cmpFlag}, 1);
    chk("R8 enc held", {31'h0, encFlag}, 1);
    chk("R8 no err", {31'h0, shortErr}, 0);
    chk("R8 no pulse", {31'h0, resultValid}, 0);

    // R7: short images
    sendImage(100, 2'b10, 1'b0, 1'b1, 1, 1, 1);
    repeat (4) @(negedge clk);
    chk("R7 err held", {31'h0, shortErr}, 1);
    chk("R7 ratio untouched", {30'h0, ratioCode}, 0);
    sendImage(50, 2'b11, 1'b0, 1'b0, 0, 1, 1);
    chk("R7 enc unseen", {31'h0, encFlag}, 0);
    sendImage(1, 2'b00, 1'b1, 1'b0, 0, 1, 1);
    sendImage(230, 2'b00, 1'b0, 1'b1, 0, 1, 1);

    // R9: restart in the middle of an image
    sendImage(120, 2'b11, 1'b0, 1'b1, 0, 1, 0);
    sendImage(230, 2'b00, 1'b1, 1'b1, 1, 1, 1);
    chk("R9 enc after restart", {31'h0, encFlag}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule